// File: doc/BRIEF.md
# SHA-1 Message Schedule Window

This block supplies the 32-bit schedule word for each of the 80 SHA-1 rounds from one 512-bit message block. It does not keep an 80-word schedule. It holds 16 registers of 32 bits and slides them forward one step per round, in step with the compression datapath that consumes the words.

A load strobe copies the block into the window and restarts the round count at zero. The most significant 32 bits of the block become word 0. After each load, the word for round 0 is on the output.

An advance strobe moves to the next round, and the output then shows the word for that round. In rounds 0 to 15 the output is the matching block word, read straight from the window. From round 16 onward the output is formed from four window taps, and each advance pushes that word in and discards the oldest one.

Top module: `sha1_sched_window`

## Requirements
- R1: While reset is asserted, and after reset until the first load, `word_o` is zero. Reset is asynchronous and active-low.
- R2: One clock edge after `init_i` is sampled high, `word_o` equals bits [511:480] of the `block_i` value sampled on that edge.
- R3: In rounds t = 1 to 15, `word_o` equals block bits [511-32t : 480-32t].
- R4: In rounds t = 16 to 79, `word_o` equals rotl1(W[t-3] ^ W[t-8] ^ W[t-14] ^ W[t-16]). Here rotl1 rotates left by one bit, and W[k] is the word output in round k.
- R5: Each `next_i` sampled high advances exactly one round. While neither strobe is high, `word_o` holds its value.
- R6: Once round 79 is reached, `next_i` has no effect, and `word_o` keeps showing W[79].
- R7: `init_i` takes precedence over `next_i` and restarts at round 0 from any round.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Load the block and restart at round 0 |
| next_i | input | 1 | Advance by one round |
| block_i | input | 512 | Message block; word 0 is in the top 32 bits |
| word_o | output | 32 | Schedule word for the current round |

## Verification
Every result is due one clock edge after the strobe that causes it. A load or an advance updates the window and the round counter on that edge, and the output word follows from those registers with no further delay.

The bench drives strobes on the falling edge. It samples `word_o` one time unit after the next rising edge. For each of several blocks it compares the output against an 80-word schedule it computes itself.

Hold, saturation, precedence and reset are then checked by directed tests. These tests also observe the output on the cycles between strobes, where it must not change.

// File: rtl/sha1_sched_pkg.sv
package sha1_sched_pkg;
  localparam int unsigned SCHED_WORD_W = 32;
  localparam int unsigned SCHED_DEPTH  = 16;
  localparam int unsigned SCHED_ROUNDS = 80;

  // Tap distances back from the word being formed.
  localparam int unsigned TAP_DIST_A = 3;
  localparam int unsigned TAP_DIST_B = 8;
  localparam int unsigned TAP_DIST_C = 14;
  localparam int unsigned TAP_DIST_D = 16;
endpackage

// File: rtl/sched_round_ctr.sv
module sched_round_ctr #(
  parameter int unsigned ROUNDS = 80,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned CNT_W = $clog2(ROUNDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_i,
  input  logic             next_i,
  output logic [CNT_W-1:0] round_o,
  output logic             direct_o,
  output logic             last_o
);
  logic [CNT_W-1:0] round_q, round_d;
  logic             cnt_en;

  assign last_o   = (round_q == CNT_W'(ROUNDS - 1));
  assign direct_o = (round_q < CNT_W'(DEPTH));
  assign cnt_en   = init_i | next_i;

  always_comb begin
    round_d = round_q;
    if (init_i)
      round_d = '0;
    else if (next_i && !last_o)
      round_d = round_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      round_q <= '0;
    else if (cnt_en)
      round_q <= round_d;
  end

  assign round_o = round_q;
endmodule

// File: rtl/sched_expand.sv
module sched_expand
  import sha1_sched_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 16
) (
  input  logic [DEPTH-1:0][WORD_W-1:0] win_i,
  output logic [WORD_W-1:0]            word_o
);
  // Entry 0 is the oldest word, W[t-16]; entry DEPTH-1 is W[t-1].
  localparam int unsigned IDX_A = DEPTH - TAP_DIST_A;
  localparam int unsigned IDX_B = DEPTH - TAP_DIST_B;
  localparam int unsigned IDX_C = DEPTH - TAP_DIST_C;
  localparam int unsigned IDX_D = DEPTH - TAP_DIST_D;

  logic [WORD_W-1:0] mix;

  assign mix    = win_i[IDX_A] ^ win_i[IDX_B] ^ win_i[IDX_C] ^ win_i[IDX_D];
  assign word_o = {mix[WORD_W-2:0], mix[WORD_W-1]};
endmodule

// File: rtl/sched_window.sv
module sched_window #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned BLK_W = WORD_W * DEPTH
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load_i,
  input  logic                         shift_i,
  input  logic [BLK_W-1:0]             block_i,
  input  logic [WORD_W-1:0]            fill_i,
  output logic [DEPTH-1:0][WORD_W-1:0] win_o
);
  logic [DEPTH-1:0][WORD_W-1:0] win_q, win_d;
  logic                         win_en;

  assign win_en = load_i | shift_i;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_comb begin
      win_d[i] = win_q[i];
      if (load_i)
        win_d[i] = block_i[BLK_W-1-i*WORD_W -: WORD_W];
      else if (shift_i) begin
        if (i == DEPTH - 1)
          win_d[i] = fill_i;
        else
          win_d[i] = win_q[(i + 1) % DEPTH];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        win_q[i] <= '0;
      else if (win_en)
        win_q[i] <= win_d[i];
    end
  end

  assign win_o = win_q;
endmodule

// File: rtl/sha1_sched_window.sv
module sha1_sched_window
  import sha1_sched_pkg::*;
#(
  parameter int unsigned WORD_W = SCHED_WORD_W,
  parameter int unsigned DEPTH  = SCHED_DEPTH,
  parameter int unsigned ROUNDS = SCHED_ROUNDS,
  localparam int unsigned BLK_W = WORD_W * DEPTH,
  localparam int unsigned CNT_W = $clog2(ROUNDS),
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_i,
  input  logic              next_i,
  input  logic [BLK_W-1:0]  block_i,
  output logic [WORD_W-1:0] word_o
);
  // Reset: asynchronous assertion, synchronous release.
  logic rst_meta_q, rst_n_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_sync <= rst_meta_q;
    end
  end

  logic [CNT_W-1:0]             round_q;
  logic                         direct;
  logic                         last;
  logic                         shift;
  logic [DEPTH-1:0][WORD_W-1:0] win;
  logic [WORD_W-1:0]            grown;

  sched_round_ctr #(.ROUNDS(ROUNDS), .DEPTH(DEPTH)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .init_i   (init_i),
    .next_i   (next_i),
    .round_o  (round_q),
    .direct_o (direct),
    .last_o   (last)
  );

  // The window only slides once the block words have been used up.
  assign shift = next_i & ~init_i & ~direct & ~last;

  sched_window #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_win (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .load_i  (init_i),
    .shift_i (shift),
    .block_i (block_i),
    .fill_i  (grown),
    .win_o   (win)
  );

  sched_expand #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_exp (
    .win_i  (win),
    .word_o (grown)
  );

  assign word_o = direct ? win[round_q[IDX_W-1:0]] : grown;
endmodule

// File: rtl/sha1_sched_window_chk.sv
module sha1_sched_window_chk #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ROUNDS = 80,
  localparam int unsigned BLK_W = WORD_W * DEPTH,
  localparam int unsigned CNT_W = $clog2(ROUNDS)
) (
  input logic              clk,
  input logic              rst_ns,
  input logic              init_i,
  input logic              next_i,
  input logic [BLK_W-1:0]  block_i,
  input logic [WORD_W-1:0] word_o,
  input logic [CNT_W-1:0]  round_q
);
  p_init_word_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    init_i |=> word_o == $past(block_i[BLK_W-1 -: WORD_W]));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_ns)
    (!init_i && !next_i) |=> $stable(word_o));

  p_one_step_r5: assert property (@(posedge clk) disable iff (!rst_ns)
    (next_i && !init_i && round_q != CNT_W'(ROUNDS - 1)) |=> round_q == $past(round_q) + CNT_W'(1));

  p_saturate_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    (!init_i && round_q == CNT_W'(ROUNDS - 1)) |=> ($stable(word_o) && round_q == CNT_W'(ROUNDS - 1)));

  p_range_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    round_q <= CNT_W'(ROUNDS - 1));

  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    init_i |=> round_q == '0);
endmodule

bind sha1_sched_window sha1_sched_window_chk #(
  .WORD_W(WORD_W), .DEPTH(DEPTH), .ROUNDS(ROUNDS)
) u_chk (
  .clk     (clk),
  .rst_ns  (rst_n_sync),
  .init_i  (init_i),
  .next_i  (next_i),
  .block_i (block_i),
  .word_o  (word_o),
  .round_q (round_q)
);

// File: tb/tb_sha1_sched_window.sv
module tb_sha1_sched_window;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 4;
  localparam logic [511:0] VEC [NVEC] = '{
    {32'h61626380, {14{32'h0}}, 32'h00000018},
    {8{64'hDEADBEEF_01234567}},
    {512{1'b1}},
    {32'h00000001, 32'h80000000, {12{32'h0}}, 32'h0F0F0F0F, 32'hF0F0F0F0}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         init_i = 1'b0;
  logic         next_i = 1'b0;
  logic [511:0] block_i = '0;
  logic [31:0]  word_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [31:0] sched [80];

  sha1_sched_window dut (
    .clk(clk), .rst_n(rst_n), .init_i(init_i), .next_i(next_i),
    .block_i(block_i), .word_o(word_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic void build(input logic [511:0] b);
    for (int k = 0; k < 80; k++) begin
      if (k < 16) sched[k] = b[511-32*k -: 32];
      else begin
        logic [31:0] x;
        x = sched[k-3] ^ sched[k-8] ^ sched[k-14] ^ sched[k-16];
        sched[k] = {x[30:0], x[31]};
      end
    end
  endfunction

  task automatic check(input string req, input logic [31:0] exp);
    total++;
    if (word_o !== exp) begin
      bad++;
      $display("FAIL %s: word_o=%h expected=%h", req, word_o, exp);
    end
  endtask

  // Drive on the falling edge, sample just after the rising edge.
  task automatic pulse(input logic ini, input logic nxt, input logic [511:0] b);
    @(negedge clk);
    init_i = ini; next_i = nxt; block_i = b;
    @(posedge clk); #1;
    init_i = 1'b0; next_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: word_o=%h expected=finish", word_o);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    check("R1 in reset", 32'h0);
    rst_n = 1'b1;
    idle(4);
    check("R1 after release", 32'h0);

    // Table walk over every round of every block.
    for (int v = 0; v < NVEC; v++) begin
      build(VEC[v]);
      pulse(1'b1, 1'b0, VEC[v]);
      check("R2 load", sched[0]);
      for (int t = 1; t < 80; t++) begin
        pulse(1'b0, 1'b1, '0);
        check(t < 16 ? "R3 direct word" : "R4 expanded word", sched[t]);
      end
      pulse(1'b0, 1'b1, '0);
      check("R6 next at last round", sched[79]);
      pulse(1'b0, 1'b1, '0);
      check("R6 repeated next", sched[79]);
    end

    // Hold without strobes, in both phases.
    build(VEC[1]);
    pulse(1'b1, 1'b0, VEC[1]);
    for (int t = 1; t <= 5; t++) pulse(1'b0, 1'b1, '0);
    block_i = VEC[2];
    idle(3);
    check("R5 hold direct phase", sched[5]);
    for (int t = 6; t <= 20; t++) pulse(1'b0, 1'b1, '0);
    idle(3);
    check("R5 hold expanded phase", sched[20]);
    pulse(1'b0, 1'b1, '0);
    check("R5 single step", sched[21]);

    // Precedence: load and advance together in round 30.
    for (int t = 22; t <= 30; t++) pulse(1'b0, 1'b1, '0);
    check("R4 round 30", sched[30]);
    build(VEC[3]);
    pulse(1'b1, 1'b1, VEC[3]);
    check("R7 init over next", sched[0]);
    pulse(1'b0, 1'b1, '0);
    check("R7 resume after restart", sched[1]);

    // Asynchronous reset in mid-run.
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", 32'h0);
    idle(2);
    rst_n = 1'b1;
    idle(4);
    check("R1 after second release", 32'h0);
    build(VEC[0]);
    pulse(1'b1, 1'b0, VEC[0]);
    check("R2 load after reset", sched[0]);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule